// File: doc/BRIEF.md
# Time-Shared Multiply-Accumulate FIR Filter

This block is a single-channel low-pass FIR filter that builds every output with one shared multiply-accumulate unit. Input samples come in at a slow rate, one strobe per sample. The filter runs on a fast processing clock. Each accepted sample is written into a circular history store. A sequencer then walks the whole coefficient set against that history, newest sample first, adding one product per processing clock. When the last product is in, the result is presented with a one-cycle valid pulse.

For one output to finish per input sample, the processing clock must be at least the tap count times the sample rate. For 56 taps at a 15 MHz sample rate this is 840 MHz. In this design the filter needs TAPS + 1 clocks per sample: the sample can be accepted in the same cycle that the previous result is presented. A strobe that arrives while a computation is still running is dropped, and a sticky flag records the drop.

The sequencer has three states. IDLE waits for a strobe. RUN adds one product per cycle. DONE presents the result. The transitions are:
- IDLE→RUN when a strobe is accepted.
- RUN→RUN while taps remain.
- RUN→DONE after the last tap.
- DONE→RUN when a strobe arrives in the presentation cycle.
- DONE→IDLE otherwise.

Top module: `fir_single_mac`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `busy` and `overrun` are 0. Reset also clears the sample history to zero, so the first output after reset only sees the newest sample.
- R2: The weight of tap k (k = 0 is the newest sample) is derived from m = min(k, TAPS-1-k). The weight is ((37·m + 13) mod 256) − 128. For example, tap 0 has weight −115 and tap 1 has weight −78.
- R3: Let x0 be the accepted sample and x1, x2, … the samples accepted before it. The output is the sum of weight(k)·xk over all k, with a missing history entry counted as 0.
- R4: `sample_valid` is accepted when it is sampled high at clock edge e. `out_valid` is then high for exactly one cycle, directly after edge e+TAPS, with the result on `out_data`.
- R5: `busy` is high for exactly TAPS cycles, starting directly after the accepting edge.
- R6: A strobe sampled while `busy` is high is discarded. It never enters the history used by later outputs.
- R7: A discarded strobe sets `overrun`. `overrun` then stays at 1 until reset.
- R8: A strobe in the cycle where `out_valid` is high is accepted without setting `overrun`. This gives a throughput of one sample every TAPS+1 clocks.
- R9: Samples are 12-bit signed, weights 8-bit signed, and the result is 26-bit signed. Full-scale inputs (−2048 or +2047 on every tap) give the exact sum, with no wrap.
- R10: The history keeps only the newest TAPS accepted samples. Older samples drop out once more than TAPS samples have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processing clock |
| rst | input | 1 | asynchronous reset, active high |
| sample_valid | input | 1 | one-cycle strobe offering a new sample |
| sample_in | input | 12 | signed sample offered with the strobe |
| out_valid | output | 1 | one-cycle pulse, result present |
| out_data | output | 26 | signed filter result, meaningful while out_valid is high |
| busy | output | 1 | high while products are being accumulated |
| overrun | output | 1 | sticky flag set by a dropped strobe |

## Verification
Two functions can land in the same cycle. The first collision is a result being presented while the next sample is accepted: the bench paces strobes so that each one arrives exactly in the `out_valid` cycle. It then judges that the new sample is taken, that `overrun` stays low, and that the next result lands TAPS edges later. The second collision is a strobe arriving on the final accumulation cycle, one cycle before DONE. It also provokes a strobe one cycle after acceptance. Both must be dropped: the bench checks that `overrun` rises and that the later results are computed from a history that omits those samples.

// File: rtl/fir_mac_pkg.sv
`timescale 1ns/1ps
package fir_mac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } seq_state_t;

    // Tap weight, symmetric about the centre of the tap line (R2).
    function automatic int tap_weight(input int k, input int taps, input int cw);
        int m;
        int span;
        m    = (k < taps - 1 - k) ? k : (taps - 1 - k);
        span = 1 << cw;
        return ((m * 37 + 13) % span) - (span / 2);
    endfunction

endpackage

// File: rtl/fir_coef_rom.sv
`timescale 1ns/1ps
module fir_coef_rom #(
    parameter int TAPS   = 56,
    parameter int COEF_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic        [IDX_W-1:0]  idx,
    output logic signed [COEF_W-1:0] coef
);
    import fir_mac_pkg::*;

    logic signed [COEF_W-1:0] weights [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_rom
        assign weights[i] = COEF_W'(tap_weight(i, TAPS, COEF_W));
    end

    always_comb begin
        if (int'(idx) < TAPS) begin
            coef = weights[idx];
        end else begin
            coef = '0;
        end
    end

endmodule

// File: rtl/fir_sample_ram.sv
`timescale 1ns/1ps
module fir_sample_ram #(
    parameter int DEPTH  = 56,
    parameter int DATA_W = 12,
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic        [ADDR_W-1:0] wr_addr,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic        [ADDR_W-1:0] rd_addr,
    output logic signed [DATA_W-1:0] rd_data
);
    logic signed [DATA_W-1:0] store [DEPTH];

    // History is cleared by reset so early outputs see zeros (R1).
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                store[i] <= '0;
            end
        end else if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (int'(rd_addr) < DEPTH) begin
            rd_data = store[rd_addr];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/fir_mac.sv
`timescale 1ns/1ps
module fir_mac #(
    parameter int SAMPLE_W = 12,
    parameter int COEF_W   = 8,
    parameter int ACC_W    = 26
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [COEF_W-1:0]   coef,
    output logic signed [ACC_W-1:0]    acc
);
    localparam int PROD_W = SAMPLE_W + COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    assign prod     = PROD_W'(sample) * PROD_W'(coef);
    assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

    // Growth bits cover TAPS full-scale products (R9).
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod_ext;
        end
    end

endmodule

// File: rtl/fir_sequencer.sv
`timescale 1ns/1ps
module fir_sequencer #(
    parameter int TAPS  = 56,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid,
    output logic [IDX_W-1:0] tap_idx,
    output logic [IDX_W-1:0] rd_addr,
    output logic [IDX_W-1:0] wr_addr,
    output logic             wr_en,
    output logic             mac_clr,
    output logic             mac_en,
    output logic             busy,
    output logic             out_valid,
    output logic             overrun
);
    import fir_mac_pkg::*;

    localparam logic [IDX_W-1:0] LAST_TAP = IDX_W'(TAPS - 1);
    localparam logic [IDX_W:0]   DEPTH_X  = (IDX_W + 1)'(TAPS);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] tap_q;
    logic [IDX_W-1:0] wptr_q;
    logic [IDX_W-1:0] newest_q;
    logic             ovr_q;
    logic             accept;
    logic [IDX_W:0]   back_addr;

    // Accepted in IDLE or in the presentation cycle (R8); dropped in RUN (R6).
    assign accept = sample_valid && (state_q != ST_RUN);

    // State register.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (tap_q == LAST_TAP) state_d = ST_DONE;
            ST_DONE: state_d = accept ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Tap counter, circular write pointer, newest-sample pointer, drop flag.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            tap_q    <= '0;
            wptr_q   <= '0;
            newest_q <= '0;
            ovr_q    <= 1'b0;
        end else begin
            if (accept) begin
                tap_q    <= '0;
                newest_q <= wptr_q;
                wptr_q   <= (wptr_q == LAST_TAP) ? '0 : wptr_q + 1'b1;
            end else if (state_q == ST_RUN) begin
                tap_q <= tap_q + 1'b1;
            end
            if (sample_valid && state_q == ST_RUN) begin
                ovr_q <= 1'b1;
            end
        end
    end

    // Read address walks backwards from the newest sample with wrap (R10).
    always_comb begin
        if (newest_q >= tap_q) begin
            back_addr = {1'b0, newest_q} - {1'b0, tap_q};
        end else begin
            back_addr = {1'b0, newest_q} + DEPTH_X - {1'b0, tap_q};
        end
    end

    // Outputs.
    always_comb begin
        tap_idx   = tap_q;
        rd_addr   = back_addr[IDX_W-1:0];
        wr_addr   = wptr_q;
        wr_en     = accept;
        mac_clr   = accept;
        mac_en    = 1'b0;
        busy      = 1'b0;
        out_valid = 1'b0;
        overrun   = ovr_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                mac_en = 1'b1;
                busy   = 1'b1;
            end
            ST_DONE: out_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fir_single_mac.sv
`timescale 1ns/1ps
module fir_single_mac #(
    parameter int TAPS     = 56,
    parameter int SAMPLE_W = 12,
    parameter int COEF_W   = 8,
    parameter int IDX_W    = $clog2(TAPS),
    parameter int ACC_W    = SAMPLE_W + COEF_W + $clog2(TAPS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic                       out_valid,
    output logic signed [ACC_W-1:0]    out_data,
    output logic                       busy,
    output logic                       overrun
);
    logic        [IDX_W-1:0]    tap_idx;
    logic        [IDX_W-1:0]    rd_addr;
    logic        [IDX_W-1:0]    wr_addr;
    logic                       wr_en;
    logic                       mac_clr;
    logic                       mac_en;
    logic signed [SAMPLE_W-1:0] hist_sample;
    logic signed [COEF_W-1:0]   weight;

    fir_sequencer #(
        .TAPS  (TAPS),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .tap_idx      (tap_idx),
        .rd_addr      (rd_addr),
        .wr_addr      (wr_addr),
        .wr_en        (wr_en),
        .mac_clr      (mac_clr),
        .mac_en       (mac_en),
        .busy         (busy),
        .out_valid    (out_valid),
        .overrun      (overrun)
    );

    fir_sample_ram #(
        .DEPTH  (TAPS),
        .DATA_W (SAMPLE_W),
        .ADDR_W (IDX_W)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (sample_in),
        .rd_addr (rd_addr),
        .rd_data (hist_sample)
    );

    fir_coef_rom #(
        .TAPS   (TAPS),
        .COEF_W (COEF_W),
        .IDX_W  (IDX_W)
    ) u_rom (
        .idx  (tap_idx),
        .coef (weight)
    );

    fir_mac #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .ACC_W    (ACC_W)
    ) u_mac (
        .clk    (clk),
        .rst    (rst),
        .clr    (mac_clr),
        .en     (mac_en),
        .sample (hist_sample),
        .coef   (weight),
        .acc    (out_data)
    );

endmodule

// File: rtl/fir_single_mac_chk.sv
`timescale 1ns/1ps
module fir_single_mac_chk #(
    parameter int TAPS = 56
) (
    input logic clk,
    input logic rst,
    input logic sample_valid,
    input logic out_valid,
    input logic busy,
    input logic overrun
);
    int run_len;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            run_len <= 0;
        end else if (busy) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r4_valid_ends_run: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(busy) && !busy));

    a_r5_run_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == TAPS));

    a_r5_accept_starts: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && !busy) |=> busy);

    a_r6_drop_flags: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(sample_valid && busy));

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r8_no_flag_on_done: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sample_valid && !overrun) |=> !overrun);

endmodule

bind fir_single_mac fir_single_mac_chk #(.TAPS(TAPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .out_valid    (out_valid),
    .busy         (busy),
    .overrun      (overrun)
);

// File: tb/fir_single_mac_tb.sv
`timescale 1ns/1ps
module fir_single_mac_tb;
    localparam int TAPS = 56;
    localparam int SW   = 12;
    localparam int CW   = 8;
    localparam int AW   = 26;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sample_valid = 1'b0;
    logic signed [SW-1:0] sample_in = '0;
    logic                 out_valid;
    logic signed [AW-1:0] out_data;
    logic                 busy;
    logic                 overrun;

    fir_single_mac u_dut (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_in    (sample_in),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .busy         (busy),
        .overrun      (overrun)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int       nchk = 0;
    int       nfail = 0;
    longint   exp_q[$];
    int       when_q[$];
    string    tag_q[$];
    int       hist[$];
    int       last_acc = -100000;
    bit       model_ovr = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int weight_of(input int k);
        int m;
        m = (k < TAPS - 1 - k) ? k : (TAPS - 1 - k);
        return ((37 * m + 13) % 256) - 128;
    endfunction

    function automatic longint model_sum();
        longint s;
        s = 0;
        for (int k = 0; k < TAPS; k++) begin
            if (k < hist.size()) s += longint'(weight_of(k)) * longint'(hist[k]);
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: called at a negedge; strobes one sample and updates the model.
    task automatic strobe(input int v, input string tag);
        sample_valid = 1'b1;
        sample_in    = v[SW-1:0];
        @(posedge clk);
        #1;
        sample_valid = 1'b0;
        if (cyc >= last_acc + TAPS + 1) begin
            last_acc = cyc;
            hist.push_front(v);
            if (hist.size() > TAPS) void'(hist.pop_back());
            exp_q.push_back(model_sum());
            when_q.push_back(cyc + TAPS);
            tag_q.push_back(tag);
        end else begin
            model_ovr = 1'b1;
        end
    endtask

    task automatic send(input int v, input string tag, input int extra);
        @(negedge clk);
        while (cyc + 1 < last_acc + TAPS + 1) @(negedge clk);
        repeat (extra) @(negedge clk);
        strobe(v, tag);
    endtask

    task automatic next_rand(output int v);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v = int'($signed(lfsr[11:0]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        hist.delete();
        model_ovr = 1'b0;
        last_acc  = -100000;
        rst = 1'b0;
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        longint e;
        int     t;
        string  tg;
        if (!rst) begin
            chk(overrun == model_ovr, "R7", "overrun", longint'(overrun), longint'(model_ovr));
            chk(busy == (cyc >= last_acc && cyc < last_acc + TAPS), "R5", "busy",
                longint'(busy), longint'(cyc >= last_acc && cyc < last_acc + TAPS));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected out_valid", 1, 0);
                end else begin
                    e  = exp_q.pop_front();
                    t  = when_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(longint'(out_data) == e, tg, "out_data", longint'(out_data), e);
                    chk(cyc == t, "R4", "out_valid edge", cyc, t);
                end
            end
        end
    end

    task automatic drain();
        repeat (TAPS + 4) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "results outstanding", exp_q.size(), 0);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0 && overrun == 1'b0, "R1", "outputs in reset",
            {out_valid, busy, overrun}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0 && overrun == 1'b0, "R1", "outputs after reset",
            {out_valid, busy, overrun}, 0);

        // Impulse: successive outputs expose the tap weights.
        send(1, "R1", 0);
        for (int k = 1; k < 6; k++) send(0, "R2", 0);
        send(0, "R2", 3);
        send(0, "R2", 0);

        // Mixed data, back-to-back and gapped, past the history depth.
        for (int i = 0; i < 64; i++) begin
            next_rand(v);
            send(v, (i < 50) ? "R3" : "R10", i % 3);
        end

        // Collision: strobes one cycle into the run and on its last cycle.
        send(100, "R8", 0);
        @(negedge clk);
        strobe(77, "R6");
        chk(overrun == 1'b1, "R7", "flag after early drop", overrun, 1);
        @(negedge clk);
        while (cyc + 1 < last_acc + TAPS) @(negedge clk);
        strobe(-55, "R6");
        send(5, "R6", 0);
        send(-9, "R6", 1);
        chk(overrun == 1'b1, "R7", "flag still set", overrun, 1);

        // Full-scale inputs of both signs.
        for (int i = 0; i < TAPS + 4; i++) send(-2048, "R9", 0);
        for (int i = 0; i < TAPS + 4; i++) send(2047, "R9", 0);
        drain();

        // Reset clears the flag and the history.
        do_reset();
        @(negedge clk);
        chk(overrun == 1'b0 && busy == 1'b0 && out_valid == 1'b0, "R7", "cleared by reset",
            {out_valid, busy, overrun}, 0);
        send(3, "R1", 0);
        send(-4, "R1", 0);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #2000000;
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule